// File: doc/BRIEF.md
# Control Endpoint Handshake and Flag Logic

This block decides the handshake a USB device returns on one control endpoint and keeps that endpoint's interrupt flags. A packet engine hands it one decoded token event at a time: the token kind (SETUP, OUT or IN) and whether the data phase of the transaction completed cleanly. The bank logic supplies a retry-required level. Firmware reaches the flags through per-bit set and clear strobes. One cycle after each token event the block reports its answer: ACK, NAK, STALL, or "send the committed bank" for an IN token. A corrupted SETUP or OUT gets no handshake at all.

Token events arrive as a valid strobe with no back-pressure. The block takes one event on every cycle where `tok_valid` is high, and the packet engine must take each result on the cycle `hs_valid` is high. The firmware strobes and flag outputs are plain level signals. A SETUP is always acknowledged and cancels any pending stall. A bank that needs a retry outranks a stall request. SETUP arrival and OUT-data arrival are reported on separate flags.

Top module: `usb_ctrl_ep_hs`

## Requirements
- R1: A `tok_valid` cycle with `tok_kind`=0 (SETUP) and `tok_ok`=1 gives `hs_valid`=1 with `hs_code`=1 (ACK) on the next cycle. This holds regardless of any stall request, retry level or occupied bank.
- R2: A clean SETUP sets flag bit 0 (setup-received) and clears flag bit 4 (stall-request) and flag bit 5 (stalled-sent) at the same edge. This clear wins over a firmware set of bit 4 in the same cycle.
- R3: A SETUP never sets flag bit 1 (out-received).
- R4: A clean OUT (`tok_kind`=1, `tok_ok`=1) with no retry and no stall request returns ACK and sets bit 1 if bit 1 was clear. If bit 1 was already set it returns NAK (`hs_code`=2) and leaves bit 1 set.
- R5: An IN (`tok_kind`=2) with no retry and no stall request returns NAK if flag bit 2 (in-ready) is set. Otherwise it returns `hs_code`=0 (send the committed bank, which may be zero-length) and sets bit 2 again only when `tok_ok`=1.
- R6: When `retry_req` is high, an OUT with `tok_ok`=1 or any IN returns NAK, even with the stall request set.
- R7: Every IN answered with NAK sets flag bit 3 (NAKed-IN).
- R8: Flag bits 6 and 7 (FIFO-control and read/write-allowed) always read 0, and firmware set strobes on them have no effect.
- R9: Every STALL handshake (`hs_code`=3) sets bit 5 at the edge that presents it. A firmware clear of bit 5 removes it.
- R10: After reset `flags` is 8'h04 (only in-ready set) and `hs_valid` is 0.
- R11: An OUT or SETUP with `tok_ok`=0, or a token with `tok_kind`=3, gives no handshake and changes no flag.
- R12: `fw_clr[i]` clears flag i. `fw_set` acts only on bit 4. When hardware sets a flag and firmware clears it in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | A token event is present this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 ignored |
| tok_ok | input | 1 | Data phase completed without error (host ACK for IN) |
| retry_req | input | 1 | Bank logic requires a retry |
| fw_set | input | 8 | Firmware set strobes, one per flag bit |
| fw_clr | input | 8 | Firmware clear strobes, one per flag bit |
| hs_valid | output | 1 | Handshake decision present |
| hs_code | output | 2 | 0 send bank data, 1 ACK, 2 NAK, 3 STALL |
| flags | output | 8 | Bit 0 setup, 1 out, 2 in-ready, 3 NAKed-IN, 4 stall-request, 5 stalled, 6/7 tied zero |

## Verification
Every flag is visible on `flags` one edge after the event that should have moved it, so a lost or stuck flag appears at the next sample. A flag that is wrong but still looks plausible shows up on the next token: a stale out-received bit turns an expected ACK into NAK, and a stall request not wiped by a SETUP turns the next OUT into STALL. The bench therefore runs tokens back to back after each flag change, and compares the handshake stream with a queue of expected codes as well as checking the flag vector.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int FLAG_W = 8;

  localparam int F_SETUP   = 0;
  localparam int F_OUT     = 1;
  localparam int F_INRDY   = 2;
  localparam int F_NAKIN   = 3;
  localparam int F_STALLRQ = 4;
  localparam int F_STALLED = 5;
  localparam int F_FIFOCTL = 6;
  localparam int F_RWOK    = 7;

  localparam logic [FLAG_W-1:0] FLAG_RST    = FLAG_W'(1) << F_INRDY;
  localparam logic [FLAG_W-1:0] FW_SETTABLE = FLAG_W'(1) << F_STALLRQ;
  localparam logic [FLAG_W-1:0] TIED_ZERO   = (FLAG_W'(1) << F_FIFOCTL) | (FLAG_W'(1) << F_RWOK);

  typedef enum logic [1:0] {
    TK_SETUP = 2'd0,
    TK_OUT   = 2'd1,
    TK_IN    = 2'd2,
    TK_RSVD  = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_DATA  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;
endpackage

// File: rtl/usb_ep_hs_decide.sv
module usb_ep_hs_decide
  import usb_ep_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         tok_valid,
  input  logic [1:0]   tok_kind,
  input  logic         tok_ok,
  input  logic         retry_req,
  input  logic [W-1:0] cur,
  output logic         fire,
  output logic [1:0]   code,
  output logic [W-1:0] hw_set,
  output logic [W-1:0] hw_clr
);
  tok_kind_e kind;
  hs_code_e  hs;

  assign kind = tok_kind_e'(tok_kind);
  assign code = hs;

  always_comb begin
    fire   = 1'b0;
    hs     = HS_DATA;
    hw_set = '0;
    hw_clr = '0;
    if (tok_valid) begin
      unique case (kind)
        TK_SETUP: begin
          if (tok_ok) begin
            fire              = 1'b1;
            hs                = HS_ACK;
            hw_set[F_SETUP]   = 1'b1;
            hw_clr[F_STALLRQ] = 1'b1;
            hw_clr[F_STALLED] = 1'b1;
          end
        end
        TK_OUT: begin
          if (tok_ok) begin
            fire = 1'b1;
            if (retry_req) begin
              hs = HS_NAK;
            end else if (cur[F_STALLRQ]) begin
              hs                = HS_STALL;
              hw_set[F_STALLED] = 1'b1;
            end else if (cur[F_OUT]) begin
              hs = HS_NAK;
            end else begin
              hs            = HS_ACK;
              hw_set[F_OUT] = 1'b1;
            end
          end
        end
        TK_IN: begin
          fire = 1'b1;
          if (retry_req) begin
            hs              = HS_NAK;
            hw_set[F_NAKIN] = 1'b1;
          end else if (cur[F_STALLRQ]) begin
            hs                = HS_STALL;
            hw_set[F_STALLED] = 1'b1;
          end else if (cur[F_INRDY]) begin
            hs              = HS_NAK;
            hw_set[F_NAKIN] = 1'b1;
          end else begin
            hs              = HS_DATA;
            hw_set[F_INRDY] = tok_ok;
          end
        end
        default: begin
          fire = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/usb_ep_flag_bank.sv
module usb_ep_flag_bank #(
  parameter int           W        = 8,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter logic [W-1:0] SETTABLE = '0,
  parameter logic [W-1:0] ZERO     = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fw_set,
  input  logic [W-1:0] fw_clr,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r;
    logic d;
    // firmware set, then all clears, then hardware set (hardware set wins)
    assign d = ((r | (fw_set[i] & SETTABLE[i])) & ~fw_clr[i] & ~hw_clr[i]) | hw_set[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL[i];
      else        r <= d;
    end
    assign q[i] = ZERO[i] ? 1'b0 : r;
  end
endmodule

// File: rtl/usb_ctrl_ep_hs.sv
module usb_ctrl_ep_hs
  import usb_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              tok_ok,
  input  logic              retry_req,
  input  logic [FLAG_W-1:0] fw_set,
  input  logic [FLAG_W-1:0] fw_clr,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic [FLAG_W-1:0] flags
);
  logic              fire;
  logic [1:0]        code;
  logic [FLAG_W-1:0] hw_set;
  logic [FLAG_W-1:0] hw_clr;

  usb_ep_hs_decide #(.W(FLAG_W)) decide_i (
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .tok_ok    (tok_ok),
    .retry_req (retry_req),
    .cur       (flags),
    .fire      (fire),
    .code      (code),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr)
  );

  usb_ep_flag_bank #(
    .W        (FLAG_W),
    .RST_VAL  (FLAG_RST),
    .SETTABLE (FW_SETTABLE),
    .ZERO     (TIED_ZERO)
  ) bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fw_set (fw_set),
    .fw_clr (fw_clr),
    .hw_set (hw_set),
    .hw_clr (hw_clr),
    .q      (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= 2'd0;
    end else begin
      hs_valid <= fire;
      hs_code  <= fire ? code : 2'd0;
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_hs_chk.sv
module usb_ctrl_ep_hs_chk
  import usb_ep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic              tok_ok,
  input logic              retry_req,
  input logic [FLAG_W-1:0] fw_set,
  input logic [FLAG_W-1:0] fw_clr,
  input logic              hs_valid,
  input logic [1:0]        hs_code,
  input logic [FLAG_W-1:0] flags
);
  logic clean_setup;
  assign clean_setup = tok_valid && tok_kind == 2'd0 && tok_ok;

  p_setup_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clean_setup |=> hs_valid && hs_code == 2'd1);

  p_setup_wipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clean_setup |=> flags[F_SETUP] && !flags[F_STALLRQ] && !flags[F_STALLED]);

  p_setup_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_setup && !flags[F_OUT]) |=> !flags[F_OUT]);

  p_retry_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && retry_req && (tok_kind == 2'd2 || (tok_kind == 2'd1 && tok_ok)))
      |=> hs_valid && hs_code == 2'd2);

  p_tied_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_FIFOCTL] == 1'b0 && flags[F_RWOK] == 1'b0);

  p_stall_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd3) |-> flags[F_STALLED]);

  p_bad_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ok && tok_kind != 2'd2) |=> !hs_valid);
endmodule

bind usb_ctrl_ep_hs usb_ctrl_ep_hs_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tok_valid (tok_valid),
  .tok_kind  (tok_kind),
  .tok_ok    (tok_ok),
  .retry_req (retry_req),
  .fw_set    (fw_set),
  .fw_clr    (fw_clr),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .flags     (flags)
);

// File: tb/usb_ctrl_ep_hs_tb.sv
module usb_ctrl_ep_hs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'd0;
  logic       tok_ok = 1'b0;
  logic       retry_req = 1'b0;
  logic [7:0] fw_set = 8'h00;
  logic [7:0] fw_clr = 8'h00;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [7:0] flags;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ctrl_ep_hs dut_i (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_ok(tok_ok), .retry_req(retry_req), .fw_set(fw_set), .fw_clr(fw_clr),
    .hs_valid(hs_valid), .hs_code(hs_code), .flags(flags)
  );

  // monitor: compares each handshake against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && hs_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected handshake: actual code=%0d expected none", hs_code);
      end else begin
        logic [1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (hs_code !== e) begin
          n_fail++;
          $display("FAIL %s handshake: actual=%0d expected=%0d", r, hs_code, e);
        end
      end
    end
  end

  // driver: one token event, optional firmware clear in the same cycle
  task automatic tok(input logic [1:0] k, input logic ok, input logic [7:0] fclr,
                     input bit exp_fire, input logic [1:0] exp_code, input string req);
    tok_valid = 1'b1;
    tok_kind  = k;
    tok_ok    = ok;
    fw_clr    = fclr;
    if (exp_fire) begin
      exp_q.push_back(exp_code);
      req_q.push_back(req);
    end
    @(negedge clk);
    tok_valid = 1'b0;
    tok_ok    = 1'b0;
    fw_clr    = 8'h00;
  endtask

  task automatic fw(input logic [7:0] s, input logic [7:0] c);
    fw_set = s;
    fw_clr = c;
    @(negedge clk);
    fw_set = 8'h00;
    fw_clr = 8'h00;
  endtask

  task automatic chk_flags(input logic [7:0] exp, input string req);
    n_checks++;
    if (flags !== exp) begin
      n_fail++;
      $display("FAIL %s flags: actual=%02h expected=%02h", req, flags, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk_flags(8'h04, "R10");
    n_checks++;
    if (hs_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 hs_valid: actual=%0b expected=0", hs_valid);
    end

    // R4 OUT into free bank, then into occupied bank
    tok(2'd1, 1'b1, 8'h00, 1, 2'd1, "R4");
    chk_flags(8'h06, "R4");
    tok(2'd1, 1'b1, 8'h00, 1, 2'd2, "R4");
    chk_flags(8'h06, "R4");
    fw(8'h00, 8'h02);
    chk_flags(8'h04, "R12");

    // R5 and R7: IN with nothing committed
    tok(2'd2, 1'b1, 8'h00, 1, 2'd2, "R5");
    chk_flags(8'h0C, "R7");
    fw(8'h00, 8'h0C);
    chk_flags(8'h00, "R12");
    tok(2'd2, 1'b1, 8'h00, 1, 2'd0, "R5");
    chk_flags(8'h04, "R5");
    // host does not acknowledge: bank stays committed
    fw(8'h00, 8'h04);
    tok(2'd2, 1'b0, 8'h00, 1, 2'd0, "R5");
    chk_flags(8'h00, "R5");
    tok(2'd2, 1'b1, 8'h00, 1, 2'd0, "R5");
    chk_flags(8'h04, "R5");

    // R9 stall request answered with STALL
    fw(8'h10, 8'h00);
    chk_flags(8'h14, "R12");
    tok(2'd1, 1'b1, 8'h00, 1, 2'd3, "R9");
    chk_flags(8'h34, "R9");
    tok(2'd2, 1'b1, 8'h00, 1, 2'd3, "R9");

    // R6 retry outranks stall
    retry_req = 1'b1;
    tok(2'd1, 1'b1, 8'h00, 1, 2'd2, "R6");
    tok(2'd2, 1'b1, 8'h00, 1, 2'd2, "R6");
    retry_req = 1'b0;
    chk_flags(8'h3C, "R7");
    fw(8'h00, 8'h28);
    chk_flags(8'h14, "R9");

    // R1 R2 R3 SETUP under stall
    tok(2'd1, 1'b1, 8'h00, 1, 2'd3, "R9");
    tok(2'd0, 1'b1, 8'h00, 1, 2'd1, "R1");
    chk_flags(8'h05, "R2");
    tok(2'd1, 1'b1, 8'h00, 1, 2'd1, "R2");
    chk_flags(8'h07, "R3");
    // SETUP with occupied out bank still ACKed
    tok(2'd0, 1'b1, 8'h00, 1, 2'd1, "R1");
    chk_flags(8'h07, "R1");
    fw(8'h00, 8'h03);
    chk_flags(8'h04, "R12");

    // R2: SETUP beats a firmware stall set in the same cycle
    fw_set = 8'h10;
    tok(2'd0, 1'b1, 8'h00, 1, 2'd1, "R1");
    fw_set = 8'h00;
    chk_flags(8'h05, "R2");
    fw(8'h00, 8'h01);

    // R11 corrupted packets and reserved kind
    tok(2'd1, 1'b0, 8'h00, 0, 2'd0, "R11");
    tok(2'd0, 1'b0, 8'h00, 0, 2'd0, "R11");
    tok(2'd3, 1'b1, 8'h00, 0, 2'd0, "R11");
    chk_flags(8'h04, "R11");

    // R8 tied-zero bits and non-settable bits ignore firmware set
    fw(8'hCB, 8'h00);
    chk_flags(8'h04, "R8");

    // R12 hardware set beats firmware clear
    tok(2'd1, 1'b1, 8'h02, 1, 2'd1, "R4");
    chk_flags(8'h06, "R12");

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 missing handshakes: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule